// File: doc/BRIEF.md
# Mains Loss Transfer Timing Monitor

This block watches a raw mains-valid comparator bit. It turns that bit into a clean line-OK level. The loss direction and the restore direction each have their own debounce window, counted in millisecond ticks. When a loss is confirmed, the block stores the value of a free-running millisecond timestamp and opens a transfer window. It then watches the sampled emergency LED current. The transfer is complete only after that current has stayed at or above a set fraction of its target for a set dwell time. At that point the block reports the elapsed transfer time in milliseconds.

While the window is open, the block also tracks the lowest sampled bus voltage. It counts how many times the bus sample drops below a brownout threshold. If the LED current never settles, a timeout ends the window, sets a flag, and saturates the reported time. All results stay in place until the next confirmed loss or a clear pulse. The block is meant to sit next to the emergency power controller and feed a result logger. Analog sensing and actuation are handled elsewhere.

Top module: `mains_xfer_monitor`

## Requirements
- R1: `line_ok` goes low only after the synchronised `mains_raw` has read 0 on LOSS_DB_MS consecutive `ms_tick` pulses. Any cycle in which it reads 1 again restarts the count, so a shorter dip leaves `line_ok` high.
- R2: When the first confirmed loss opens a window, `loss_ts` takes the current timestamp value. A further confirmed loss while that window is still open does not change `loss_ts`.
- R3: The timestamp advances by one on each `ms_tick` and wraps at 2^TS_W. On completion, `xfer_ms` equals the timestamp at the completing cycle minus `loss_ts`, modulo 2^TS_W.
- R4: LED current is in band when `led_i*100 >= led_target*STABLE_PCT`. The window completes (`xfer_done`=1) only after HOLD_MS consecutive ticks in band with no out-of-band cycle in between. A shorter spike does not complete it.
- R5: `vbus_min` holds the lowest `vbus` sample seen in each cycle while the window is open, and it never rises during the window.
- R6: `brownout_cnt` adds one each time `vbus` goes from not-below to below `vbus_brown` inside a window. It starts at 0 with each window and saturates at its maximum.
- R7: `line_ok` returns high only after the synchronised `mains_raw` has read 1 on RESTORE_DB_MS consecutive ticks. A shorter return leaves it low.
- R8: If the window is still open after TIMEOUT_MS ticks, `xfer_timeout` goes to 1, `xfer_ms` goes to all ones, and the window closes.
- R9: Results stay unchanged outside a window until the next confirmed loss. A `clr` pulse closes any window and returns every result to its reset value (`loss_ts`, `xfer_ms`, the flags and `brownout_cnt` at 0).
- R10: `vbus_min` reads all ones after reset, after `clr`, and at the opening of each window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mains_raw | input | 1 | Raw mains-valid comparator bit, asynchronous |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| clr | input | 1 | Clears results and aborts an open window |
| led_i | input | I_W | Sampled LED current |
| led_target | input | I_W | LED current target |
| vbus | input | V_W | Sampled bus voltage |
| vbus_brown | input | V_W | Brownout threshold |
| line_ok | output | 1 | Debounced mains-valid level |
| window_active | output | 1 | Transfer window open |
| loss_ts | output | TS_W | Timestamp latched at the confirmed loss |
| xfer_ms | output | TS_W | Transfer time in ms, all ones on timeout |
| xfer_done | output | 1 | Window completed with stable LED current |
| xfer_timeout | output | 1 | Window ended by timeout |
| vbus_min | output | V_W | Lowest bus sample in the window |
| brownout_cnt | output | BO_W | Brownout entries in the window |

## Verification
The assertions check these on every cycle: `line_ok` moves only one cycle after a tick, `loss_ts` stays frozen inside an open window, `vbus_min` never rises and `brownout_cnt` never falls while the window is open, a timeout always reports the saturated time, the two end flags never appear together or while the window is open, and results hold outside a window. Only the bench scenarios can show the rest. These include the exact debounce lengths in each direction, the rejection of a short LED spike, the cycle-exact transfer time, the brownout count over a dip pattern, and the effect of a clear. A cycle-by-cycle reference model checks these.

// File: rtl/xfer_mon_pkg.sv
// Package: shared types for the mains loss transfer timing monitor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package xfer_mon_pkg;

    // Transfer window phase
    typedef enum logic [1:0] {
        WIN_IDLE   = 2'd0,
        WIN_ACTIVE = 2'd1,
        WIN_DONE   = 2'd2
    } win_state_e;

endpackage

// File: rtl/line_qualifier.sv
// Module: line_qualifier
// Synchronises the raw mains-valid bit and debounces it into line_ok with
// separate loss and restore windows counted in ms ticks. Emits a one-cycle
// loss_pulse in the first cycle line_ok reads 0.
// Assumes LOSS_DB_MS >= 1 and RESTORE_DB_MS >= 1; mains is taken as valid at reset.
module line_qualifier #(
    parameter int LOSS_DB_MS    = 20,
    parameter int RESTORE_DB_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mains_raw,
    input  logic ms_tick,
    output logic line_ok,
    output logic loss_pulse
);

    localparam int DB_MAX = (LOSS_DB_MS > RESTORE_DB_MS) ? LOSS_DB_MS : RESTORE_DB_MS;
    localparam int DB_W   = $clog2(DB_MAX + 1);

    logic            sync_a;
    logic            sync_b;
    logic [DB_W-1:0] agree_cnt;
    logic [DB_W:0]   agree_inc;
    logic [DB_W:0]   db_limit;

    // Two-flop synchroniser for the asynchronous comparator bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= mains_raw;
            sync_b <= sync_a;
        end
    end

    // Pick the debounce length for the direction being tested
    always_comb begin
        agree_inc = {1'b0, agree_cnt} + 1'b1;
        db_limit  = line_ok ? (DB_W+1)'(LOSS_DB_MS) : (DB_W+1)'(RESTORE_DB_MS);
    end

    // Count consecutive ticks on which the input disagrees with line_ok
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ok    <= 1'b1;
            agree_cnt  <= '0;
            loss_pulse <= 1'b0;
        end else begin
            loss_pulse <= 1'b0;
            if (sync_b == line_ok) begin
                agree_cnt <= '0;
            end else if (ms_tick) begin
                if (agree_inc >= db_limit) begin
                    line_ok    <= sync_b;
                    agree_cnt  <= '0;
                    loss_pulse <= line_ok;
                end else begin
                    agree_cnt <= agree_inc[DB_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/ms_timestamp.sv
// Module: ms_timestamp
// Free-running millisecond timestamp that wraps at 2^TS_W.
// Assumes ms_tick is a single-cycle pulse.
module ms_timestamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    output logic [TS_W-1:0] ts
);

    // Advance once per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts <= '0;
        end else if (ms_tick) begin
            ts <= ts + 1'b1;
        end
    end

endmodule

// File: rtl/stable_qualifier.sv
// Module: stable_qualifier
// Decides when the LED current has been in band (at or above STABLE_PCT
// percent of target) for HOLD_MS consecutive ticks. Any out-of-band cycle
// restarts the dwell. stable is a one-cycle combinational strobe.
// Assumes STABLE_PCT <= 255 and HOLD_MS >= 1; counting only while run_en.
module stable_qualifier #(
    parameter int I_W        = 12,
    parameter int STABLE_PCT = 90,
    parameter int HOLD_MS    = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           ms_tick,
    input  logic [I_W-1:0] led_i,
    input  logic [I_W-1:0] led_target,
    output logic           stable
);

    localparam int PW = I_W + 8;
    localparam int HW = $clog2(HOLD_MS + 1);

    logic [PW-1:0] led_scaled;
    logic [PW-1:0] tgt_scaled;
    logic          in_band;
    logic [HW-1:0] dwell;
    logic [HW:0]   dwell_inc;

    // Compare current against the percentage of target without division
    always_comb begin
        led_scaled = PW'(led_i) * PW'(100);
        tgt_scaled = PW'(led_target) * PW'(STABLE_PCT);
        in_band    = (led_scaled >= tgt_scaled);
        dwell_inc  = {1'b0, dwell} + 1'b1;
        stable     = run_en && in_band && ms_tick && (dwell_inc >= (HW+1)'(HOLD_MS));
    end

    // Track the in-band dwell in ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell <= '0;
        end else if (!run_en || !in_band) begin
            dwell <= '0;
        end else if (ms_tick) begin
            dwell <= stable ? '0 : dwell_inc[HW-1:0];
        end
    end

endmodule

// File: rtl/transfer_window.sv
// Module: transfer_window
// Opens a window on a confirmed loss, latches the loss timestamp, tracks the
// bus minimum and brownout entries, and closes on stable LED current or on
// timeout. Results hold until the next loss or clr.
// Assumes loss_pulse is one cycle and TIMEOUT_MS >= 1.
module transfer_window
    import xfer_mon_pkg::*;
#(
    parameter int TS_W       = 16,
    parameter int V_W        = 12,
    parameter int BO_W       = 8,
    parameter int TIMEOUT_MS = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ms_tick,
    input  logic            loss_pulse,
    input  logic [TS_W-1:0] ts,
    input  logic            stable,
    input  logic [V_W-1:0]  vbus,
    input  logic [V_W-1:0]  vbus_brown,
    output logic            window_active,
    output logic [TS_W-1:0] loss_ts,
    output logic [TS_W-1:0] xfer_ms,
    output logic            xfer_done,
    output logic            xfer_timeout,
    output logic [V_W-1:0]  vbus_min,
    output logic [BO_W-1:0] brownout_cnt
);

    localparam int EW = $clog2(TIMEOUT_MS + 1);

    win_state_e    state;
    logic [EW-1:0] elapsed;
    logic [EW:0]   elapsed_inc;
    logic          below_prev;
    logic          below_now;

    // Derived window conditions
    always_comb begin
        window_active = (state == WIN_ACTIVE);
        elapsed_inc   = {1'b0, elapsed} + 1'b1;
        below_now     = (vbus < vbus_brown);
    end

    // Window sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state        <= WIN_IDLE;
            loss_ts      <= '0;
            xfer_ms      <= '0;
            xfer_done    <= 1'b0;
            xfer_timeout <= 1'b0;
            vbus_min     <= '1;
            brownout_cnt <= '0;
            below_prev   <= 1'b0;
            elapsed      <= '0;
        end else begin
            case (state)
                WIN_ACTIVE: begin
                    if (vbus < vbus_min) begin
                        vbus_min <= vbus;
                    end
                    below_prev <= below_now;
                    if (below_now && !below_prev && (brownout_cnt != '1)) begin
                        brownout_cnt <= brownout_cnt + 1'b1;
                    end
                    if (stable) begin
                        xfer_ms   <= ts - loss_ts;
                        xfer_done <= 1'b1;
                        state     <= WIN_DONE;
                    end else if (ms_tick) begin
                        if (elapsed_inc >= (EW+1)'(TIMEOUT_MS)) begin
                            xfer_ms      <= '1;
                            xfer_timeout <= 1'b1;
                            state        <= WIN_DONE;
                        end else begin
                            elapsed <= elapsed_inc[EW-1:0];
                        end
                    end
                end
                default: begin
                    if (loss_pulse) begin
                        state        <= WIN_ACTIVE;
                        loss_ts      <= ts;
                        xfer_ms      <= '0;
                        xfer_done    <= 1'b0;
                        xfer_timeout <= 1'b0;
                        vbus_min     <= '1;
                        brownout_cnt <= '0;
                        below_prev   <= 1'b0;
                        elapsed      <= '0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mains_xfer_monitor.sv
// Module: mains_xfer_monitor (top)
// Debounced mains detection plus transfer timing evidence: loss timestamp,
// transfer time to stable LED current, bus minimum and brownout count.
// Assumes ms_tick is a one-cycle pulse in the clk domain; mains_raw may be asynchronous.
module mains_xfer_monitor #(
    parameter int TS_W          = 16,
    parameter int V_W           = 12,
    parameter int I_W           = 12,
    parameter int BO_W          = 8,
    parameter int LOSS_DB_MS    = 20,
    parameter int RESTORE_DB_MS = 200,
    parameter int STABLE_PCT    = 90,
    parameter int HOLD_MS       = 10,
    parameter int TIMEOUT_MS    = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mains_raw,
    input  logic            ms_tick,
    input  logic            clr,
    input  logic [I_W-1:0]  led_i,
    input  logic [I_W-1:0]  led_target,
    input  logic [V_W-1:0]  vbus,
    input  logic [V_W-1:0]  vbus_brown,
    output logic            line_ok,
    output logic            window_active,
    output logic [TS_W-1:0] loss_ts,
    output logic [TS_W-1:0] xfer_ms,
    output logic            xfer_done,
    output logic            xfer_timeout,
    output logic [V_W-1:0]  vbus_min,
    output logic [BO_W-1:0] brownout_cnt
);

    logic            loss_pulse;
    logic [TS_W-1:0] ts_now;
    logic            led_stable;

    line_qualifier #(
        .LOSS_DB_MS    (LOSS_DB_MS),
        .RESTORE_DB_MS (RESTORE_DB_MS)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .mains_raw  (mains_raw),
        .ms_tick    (ms_tick),
        .line_ok    (line_ok),
        .loss_pulse (loss_pulse)
    );

    ms_timestamp #(
        .TS_W (TS_W)
    ) u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .ts      (ts_now)
    );

    stable_qualifier #(
        .I_W        (I_W),
        .STABLE_PCT (STABLE_PCT),
        .HOLD_MS    (HOLD_MS)
    ) u_stable (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (window_active),
        .ms_tick    (ms_tick),
        .led_i      (led_i),
        .led_target (led_target),
        .stable     (led_stable)
    );

    transfer_window #(
        .TS_W       (TS_W),
        .V_W        (V_W),
        .BO_W       (BO_W),
        .TIMEOUT_MS (TIMEOUT_MS)
    ) u_win (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (clr),
        .ms_tick       (ms_tick),
        .loss_pulse    (loss_pulse),
        .ts            (ts_now),
        .stable        (led_stable),
        .vbus          (vbus),
        .vbus_brown    (vbus_brown),
        .window_active (window_active),
        .loss_ts       (loss_ts),
        .xfer_ms       (xfer_ms),
        .xfer_done     (xfer_done),
        .xfer_timeout  (xfer_timeout),
        .vbus_min      (vbus_min),
        .brownout_cnt  (brownout_cnt)
    );

endmodule

// File: rtl/mains_xfer_monitor_chk.sv
// Module: mains_xfer_monitor_chk
// Property checker bound to mains_xfer_monitor; observes ports only.
module mains_xfer_monitor_chk #(
    parameter int TS_W = 16,
    parameter int V_W  = 12,
    parameter int BO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ms_tick,
    input logic            clr,
    input logic            line_ok,
    input logic            window_active,
    input logic [TS_W-1:0] loss_ts,
    input logic [TS_W-1:0] xfer_ms,
    input logic            xfer_done,
    input logic            xfer_timeout,
    input logic [V_W-1:0]  vbus_min,
    input logic [BO_W-1:0] brownout_cnt
);

    // R1 / R7: line_ok only moves in the cycle after a tick
    a_r1_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_ok) |-> $past(ms_tick));

    // R2: loss timestamp frozen while a window stays open
    a_r2_loss_ts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (window_active && $past(window_active)) |-> $stable(loss_ts));

    // R5: bus minimum never rises inside a window
    a_r5_vmin_nonrising: assert property (@(posedge clk) disable iff (!rst_n)
        (window_active && $past(window_active)) |-> (vbus_min <= $past(vbus_min)));

    // R6: brownout count never falls inside a window
    a_r6_brownout_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (window_active && $past(window_active)) |-> (brownout_cnt >= $past(brownout_cnt)));

    // R8: timeout always reports the saturated time
    a_r8_timeout_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_timeout |-> (xfer_ms == '1));

    // R4 / R8: the two end flags are exclusive and absent while open
    a_r4_end_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({xfer_done, xfer_timeout, window_active}) <= 1);

    // R9: results hold outside a window unless cleared
    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_active && !$past(window_active) && !$past(clr)) |->
            ($stable(xfer_ms) && $stable(loss_ts) && $stable(xfer_done)));

endmodule

bind mains_xfer_monitor mains_xfer_monitor_chk #(
    .TS_W (TS_W),
    .V_W  (V_W),
    .BO_W (BO_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ms_tick       (ms_tick),
    .clr           (clr),
    .line_ok       (line_ok),
    .window_active (window_active),
    .loss_ts       (loss_ts),
    .xfer_ms       (xfer_ms),
    .xfer_done     (xfer_done),
    .xfer_timeout  (xfer_timeout),
    .vbus_min      (vbus_min),
    .brownout_cnt  (brownout_cnt)
);

// File: tb/mains_xfer_monitor_tb.sv
// Bench for mains_xfer_monitor: behavioural per-cycle reference model plus
// directed scenario checks. Reports via its own counters.
module mains_xfer_monitor_tb;

    localparam int TS_W = 16;
    localparam int V_W  = 12;
    localparam int I_W  = 12;
    localparam int BO_W = 8;
    localparam int LOSS_DB = 3;
    localparam int REST_DB = 5;
    localparam int PCT     = 90;
    localparam int HOLD    = 4;
    localparam int TMO     = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mains_raw = 1'b1;
    logic ms_tick = 1'b0;
    logic clr = 1'b0;
    logic [I_W-1:0] led_i = '0;
    logic [I_W-1:0] led_target = 12'd1000;
    logic [V_W-1:0] vbus = 12'd3000;
    logic [V_W-1:0] vbus_brown = 12'd2000;
    logic            line_ok;
    logic            window_active;
    logic [TS_W-1:0] loss_ts;
    logic [TS_W-1:0] xfer_ms;
    logic            xfer_done;
    logic            xfer_timeout;
    logic [V_W-1:0]  vbus_min;
    logic [BO_W-1:0] brownout_cnt;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    int tick_div = 0;
    int t0;

    // 50 MHz clock
    always #10 clk = ~clk;

    mains_xfer_monitor #(
        .TS_W(TS_W), .V_W(V_W), .I_W(I_W), .BO_W(BO_W),
        .LOSS_DB_MS(LOSS_DB), .RESTORE_DB_MS(REST_DB),
        .STABLE_PCT(PCT), .HOLD_MS(HOLD), .TIMEOUT_MS(TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mains_raw(mains_raw), .ms_tick(ms_tick),
        .clr(clr), .led_i(led_i), .led_target(led_target), .vbus(vbus),
        .vbus_brown(vbus_brown), .line_ok(line_ok), .window_active(window_active),
        .loss_ts(loss_ts), .xfer_ms(xfer_ms), .xfer_done(xfer_done),
        .xfer_timeout(xfer_timeout), .vbus_min(vbus_min), .brownout_cnt(brownout_cnt)
    );

    // Tick every fourth cycle, driven away from the active edge
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        ms_tick  = (tick_div == 0);
    end

    // ---------------- reference model ----------------
    int m_hist[$];
    int m_ok, m_cnt, m_lp, m_ts, m_active, m_run, m_el, m_below;
    int m_lts, m_xfer, m_done, m_to, m_vmin, m_bo;

    task automatic model_reset();
        m_hist = '{1, 1};
        m_ok = 1; m_cnt = 0; m_lp = 0; m_ts = 0; m_active = 0; m_run = 0;
        m_el = 0; m_below = 0; m_lts = 0; m_xfer = 0; m_done = 0; m_to = 0;
        m_vmin = 4095; m_bo = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int seen, lim, inband, stab, n_ok, n_cnt, n_lp, n_run;
            seen   = m_hist[0];
            inband = (int'(led_i) * 100 >= int'(led_target) * PCT);
            stab   = m_active && inband && ms_tick && (m_run + 1 >= HOLD);
            // dwell of in-band ticks
            if (!m_active || !inband) n_run = 0;
            else if (ms_tick) n_run = stab ? 0 : m_run + 1;
            else n_run = m_run;
            // debounce on synchronised value
            lim = m_ok ? LOSS_DB : REST_DB;
            n_ok = m_ok; n_cnt = m_cnt; n_lp = 0;
            if (seen == m_ok) n_cnt = 0;
            else if (ms_tick) begin
                if (m_cnt + 1 >= lim) begin n_ok = seen; n_cnt = 0; n_lp = m_ok; end
                else n_cnt = m_cnt + 1;
            end
            // window
            if (clr) begin
                m_active = 0; m_lts = 0; m_xfer = 0; m_done = 0; m_to = 0;
                m_vmin = 4095; m_bo = 0; m_below = 0; m_el = 0;
            end else if (!m_active) begin
                if (m_lp) begin
                    m_active = 1; m_lts = m_ts; m_xfer = 0; m_done = 0; m_to = 0;
                    m_vmin = 4095; m_bo = 0; m_below = 0; m_el = 0;
                end
            end else begin
                if (int'(vbus) < m_vmin) m_vmin = int'(vbus);
                if (int'(vbus) < int'(vbus_brown) && !m_below && m_bo < 255) m_bo++;
                m_below = (int'(vbus) < int'(vbus_brown));
                if (stab) begin
                    m_xfer = (m_ts - m_lts) & 16'hFFFF; m_done = 1; m_active = 0;
                end else if (ms_tick) begin
                    if (m_el + 1 >= TMO) begin m_xfer = 16'hFFFF; m_to = 1; m_active = 0; end
                    else m_el++;
                end
            end
            m_run = n_run; m_ok = n_ok; m_cnt = n_cnt; m_lp = n_lp;
            if (ms_tick) m_ts = (m_ts + 1) & 16'hFFFF;
            void'(m_hist.pop_front());
            m_hist.push_back(int'(mains_raw));
        end
    end

    task automatic cmp(string req, string nm, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            cmp("R1/R7", "line_ok", int'(line_ok), m_ok);
            cmp("R2", "window_active", int'(window_active), m_active);
            cmp("R2", "loss_ts", int'(loss_ts), m_lts);
            cmp("R3", "xfer_ms", int'(xfer_ms), m_xfer);
            cmp("R4", "xfer_done", int'(xfer_done), m_done);
            cmp("R8", "xfer_timeout", int'(xfer_timeout), m_to);
            cmp("R5/R10", "vbus_min", int'(vbus_min), m_vmin);
            cmp("R6", "brownout_cnt", int'(brownout_cnt), m_bo);
        end
    end

    task automatic chk(string req, string nm, int act, int exp);
        vectors++;
        cmp(req, nm, act, exp);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus
    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // reset state (R9, R10)
        chk("R9", "reset line_ok", int'(line_ok), 1);
        chk("R9", "reset done", int'(xfer_done), 0);
        chk("R10", "reset vbus_min", int'(vbus_min), 4095);
        chk("R9", "reset brownout", int'(brownout_cnt), 0);

        // R1: short dip is rejected
        mains_raw = 1'b0; wait_cyc(6);
        mains_raw = 1'b1; wait_cyc(20);
        chk("R1", "short dip line_ok", int'(line_ok), 1);
        chk("R1", "short dip window", int'(window_active), 0);

        // Real loss with bus dips, spike, then stable current
        mains_raw = 1'b0; wait_cyc(20);
        chk("R1", "loss line_ok", int'(line_ok), 0);
        chk("R2", "window opened", int'(window_active), 1);
        vbus = 12'd2500; wait_cyc(5);
        vbus = 12'd1800; wait_cyc(3);
        vbus = 12'd2600; wait_cyc(3);
        vbus = 12'd1500; wait_cyc(3);
        vbus = 12'd2400; wait_cyc(2);
        led_i = 12'd1000; wait_cyc(3);
        led_i = 12'd0;    wait_cyc(2);
        chk("R4", "spike not done", int'(xfer_done), 0);
        led_i = 12'd950; wait_cyc(30);
        chk("R4", "stable done", int'(xfer_done), 1);
        chk("R8", "no timeout", int'(xfer_timeout), 0);
        chk("R5", "vbus_min after dips", int'(vbus_min), 1500);
        chk("R6", "brownout entries", int'(brownout_cnt), 2);
        t0 = int'(xfer_ms);
        mains_raw = 1'b1; wait_cyc(40);
        chk("R7", "restored line_ok", int'(line_ok), 1);
        chk("R9", "xfer_ms held", int'(xfer_ms), t0);

        // Second loss; mains returns and fails again inside the window
        led_i = 12'd0; vbus = 12'd3000;
        mains_raw = 1'b0; wait_cyc(30);
        t0 = int'(loss_ts);
        mains_raw = 1'b1; wait_cyc(30);
        mains_raw = 1'b0; wait_cyc(30);
        chk("R2", "relost line_ok", int'(line_ok), 0);
        chk("R2", "loss_ts kept", int'(loss_ts), t0);
        chk("R2", "window still open", int'(window_active), 1);
        wait_cyc(200);
        chk("R8", "timeout flag", int'(xfer_timeout), 1);
        chk("R8", "timeout xfer_ms", int'(xfer_ms), 65535);

        // R9/R10: clear
        clr = 1'b1; wait_cyc(1);
        clr = 1'b0; wait_cyc(2);
        chk("R9", "clr timeout", int'(xfer_timeout), 0);
        chk("R9", "clr xfer_ms", int'(xfer_ms), 0);
        chk("R10", "clr vbus_min", int'(vbus_min), 4095);
        chk("R9", "clr brownout", int'(brownout_cnt), 0);

        // R7: short return rejected, long return accepted
        mains_raw = 1'b1; wait_cyc(14);
        mains_raw = 1'b0; wait_cyc(10);
        chk("R7", "short return line_ok", int'(line_ok), 0);
        mains_raw = 1'b1; wait_cyc(40);
        chk("R7", "long return line_ok", int'(line_ok), 1);

        // Third loss reaching a quick stable result
        led_i = 12'd900; vbus = 12'd1900;
        mains_raw = 1'b0; wait_cyc(60);
        chk("R3", "third done", int'(xfer_done), 1);
        chk("R6", "third brownout", int'(brownout_cnt), 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule